// File: doc/BRIEF.md
# PS/2 Host Command Transmitter

This block sends a single command byte from a host controller to a PS/2 peripheral such as a mouse. It works the two open-collector bus wires only through output enables. An enable pulls its line low. A released line reads high through an external pull-up.

A transfer has four phases. First the host holds the clock line low for a programmable inhibit interval. Next it pulls the data line low and then lets go of the clock, which is the request. The device then clocks out the frame. The host places each bit while the device clock is low: eight data bits least significant first, then an odd-parity bit. After parity the host lets go of the data line so that the stop bit floats high. On the eleventh device falling edge the host samples the acknowledge that the device drives low.

The command byte enters through a valid/ready handshake. The ready signal is high only while the block is idle. A source holds its byte and valid until ready is seen, so a byte presented during a transfer simply waits and is never lost or duplicated. The outcome is reported on plain pins: a one-cycle done strobe, a busy level, and sticky ack and error flags that hold until the next byte is accepted.

Top module: `ps2_host_tx`

## Requirements
- R1: After reset both line enables are off, done is low, busy is low and the command ready signal is high.
- R2: A byte is accepted on a clock edge where valid and ready are both high. Ready stays low and busy stays high until the transfer finishes. A byte offered while busy is not accepted and starts no extra transfer.
- R3: After acceptance the clock enable is asserted with the data enable off for exactly INHIBIT_CYC system cycles.
- R4: After the inhibit phase the data enable is asserted for one cycle while the clock enable is still on. The clock enable is then released while the data line stays low, so the device reads a start bit of 0.
- R5: On each of the first eight synchronized falling edges of the device clock, the host drives the next data bit, least significant bit first: enable on for a 0, off for a 1. The bit is held through the following rising edge.
- R6: On the ninth falling edge the host drives the parity bit. The parity bit makes the count of ones across the eight data bits and the parity bit odd.
- R7: On the tenth falling edge the host releases the data line, so the stop bit reads 1.
- R8: On the eleventh falling edge the host samples the data line. If it reads 0, done pulses with ack_ok set to 1 and err set to 0.
- R9: If the data line reads 1 at the eleventh falling edge, done pulses with err set to 1 and ack_ok set to 0.
- R10: While waiting for a device clock edge, if TIMEOUT_CYC system cycles pass with no falling edge, done pulses with err set to 1. This covers the wait after the request and every later wait. When done pulses, both line enables are released.
- R11: Done is high for exactly one cycle. ack_ok and err keep their values until the next byte is accepted, and both clear at that acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command byte is offered |
| cmd_ready | output | 1 | Block is idle and will take the byte |
| cmd_data | input | DATA_W | Command byte |
| ps2_clk_i | input | 1 | Level read from the PS/2 clock wire |
| ps2_dat_i | input | 1 | Level read from the PS/2 data wire |
| ps2_clk_oe | output | 1 | Pulls the clock wire low when 1 |
| ps2_dat_oe | output | 1 | Pulls the data wire low when 1 |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle strobe at the end of a transfer |
| ack_ok | output | 1 | Last transfer was acknowledged |
| err | output | 1 | Last transfer ended without an acknowledge or timed out |

## Verification
A device model on the wired-AND bus records every bit it clocks in, and the scoreboard compares those bits with the queued byte. A byte of 0x01 and a byte of 0x80 are both sent, so a design that shifted MSB first would deliver a mirrored byte. Bytes with even and odd counts of ones catch an inverted parity bit, and the stop bit sample catches a host that keeps driving data after parity. The model also runs three faulty modes: it withholds the acknowledge, it never clocks, and it stops after four pulses. A design that ignored the acknowledge level, or waited without a limit, would report success or hang. A second byte offered during a transfer must not start an extra transfer. The inhibit length is counted cycle by cycle, and the start bit is read when the clock is released.

// File: rtl/ps2_tx_pkg.sv
package ps2_tx_pkg;

  typedef enum logic [1:0] {
    TX_IDLE    = 2'd0,
    TX_INHIBIT = 2'd1,
    TX_REQUEST = 2'd2,
    TX_XFER    = 2'd3
  } tx_state_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ps2_line_sync.sv
module ps2_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_s,
  output logic fall
);

  logic [STAGES-1:0] pipe;
  logic              last_q;

  // first stage samples the raw wire; released wire idles high
  always_ff @(posedge clk) begin
    if (!rst_n) pipe[0] <= 1'b1;
    else        pipe[0] <= line_i;
  end

  genvar g;
  generate
    for (g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) pipe[g] <= 1'b1;
        else        pipe[g] <= pipe[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= 1'b1;
    else        last_q <= pipe[STAGES-1];
  end

  assign line_s = pipe[STAGES-1];
  assign fall   = last_q & ~pipe[STAGES-1];

endmodule

// File: rtl/ps2_tx_shifter.sv
module ps2_tx_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic [DATA_W-1:0] data_i,
  output logic              bit_o
);

  localparam int FRAME_W = DATA_W + 1;

  logic [FRAME_W-1:0] frame_q;
  logic               odd_bit;

  // parity bit that makes the total count of ones odd
  assign odd_bit = ~(^data_i);

  always_ff @(posedge clk) begin
    if (!rst_n)     frame_q <= '1;
    else if (load)  frame_q <= {odd_bit, data_i};
    else if (shift) frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
  end

  assign bit_o = frame_q[0];

endmodule

// File: rtl/ps2_tx_timer.sv
module ps2_tx_timer #(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [TMR_W-1:0] limit,
  output logic             expire
);

  logic [TMR_W-1:0] cnt_q;

  assign expire = (cnt_q >= (limit - TMR_W'(1)));

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clr)     cnt_q <= '0;
    else if (!expire) cnt_q <= cnt_q + TMR_W'(1);
  end

endmodule

// File: rtl/ps2_host_tx.sv
module ps2_host_tx
  import ps2_tx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int INHIBIT_CYC = 12500,
  parameter int TIMEOUT_CYC = 1250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              ps2_clk_i,
  input  logic              ps2_dat_i,
  output logic              ps2_clk_oe,
  output logic              ps2_dat_oe,
  output logic              busy,
  output logic              done,
  output logic              ack_ok,
  output logic              err
);

  localparam int FRAME_BITS = DATA_W + 1;
  localparam int LAST_EDGE  = FRAME_BITS + 1;
  localparam int CNT_W      = $clog2(LAST_EDGE + 1);
  localparam int TMR_MAX    = max_int(INHIBIT_CYC, TIMEOUT_CYC);
  localparam int TMR_W      = $clog2(TMR_MAX + 1);

  tx_state_e        state_q;
  logic [CNT_W-1:0] edge_cnt_q;
  logic             dat_low_q;
  logic             clk_s, clk_fall, dat_s, dat_fall_unused;
  logic             accept, shift_en, tmr_clr, tmr_exp, sh_bit;
  logic [TMR_W-1:0] tmr_limit;

  ps2_line_sync #(.STAGES(SYNC_STAGES)) u_clk_sync (
    .clk(clk), .rst_n(rst_n), .line_i(ps2_clk_i), .line_s(clk_s), .fall(clk_fall)
  );

  ps2_line_sync #(.STAGES(SYNC_STAGES)) u_dat_sync (
    .clk(clk), .rst_n(rst_n), .line_i(ps2_dat_i), .line_s(dat_s), .fall(dat_fall_unused)
  );

  assign accept   = cmd_valid && (state_q == TX_IDLE);
  assign shift_en = (state_q == TX_XFER) && clk_fall && (edge_cnt_q < CNT_W'(FRAME_BITS));
  assign tmr_clr  = accept || (state_q == TX_REQUEST) || ((state_q == TX_XFER) && clk_fall);
  assign tmr_limit = (state_q == TX_INHIBIT) ? TMR_W'(INHIBIT_CYC) : TMR_W'(TIMEOUT_CYC);

  ps2_tx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(accept), .shift(shift_en),
    .data_i(cmd_data), .bit_o(sh_bit)
  );

  ps2_tx_timer #(.TMR_W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .limit(tmr_limit), .expire(tmr_exp)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= TX_IDLE;
      edge_cnt_q <= '0;
      dat_low_q  <= 1'b0;
      done       <= 1'b0;
      ack_ok     <= 1'b0;
      err        <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        TX_IDLE: begin
          if (cmd_valid) begin
            state_q <= TX_INHIBIT;
            ack_ok  <= 1'b0;
            err     <= 1'b0;
          end
        end
        TX_INHIBIT: begin
          if (tmr_exp) begin
            state_q   <= TX_REQUEST;
            dat_low_q <= 1'b1;
          end
        end
        TX_REQUEST: begin
          state_q    <= TX_XFER;
          edge_cnt_q <= '0;
        end
        TX_XFER: begin
          if (clk_fall) begin
            edge_cnt_q <= edge_cnt_q + CNT_W'(1);
            if (edge_cnt_q < CNT_W'(FRAME_BITS)) begin
              dat_low_q <= ~sh_bit;
            end else if (edge_cnt_q == CNT_W'(FRAME_BITS)) begin
              dat_low_q <= 1'b0;
            end else begin
              ack_ok    <= ~dat_s;
              err       <= dat_s;
              done      <= 1'b1;
              dat_low_q <= 1'b0;
              state_q   <= TX_IDLE;
            end
          end else if (tmr_exp) begin
            err       <= 1'b1;
            done      <= 1'b1;
            dat_low_q <= 1'b0;
            state_q   <= TX_IDLE;
          end
        end
        default: state_q <= TX_IDLE;
      endcase
    end
  end

  assign ps2_clk_oe = (state_q == TX_INHIBIT) || (state_q == TX_REQUEST);
  assign ps2_dat_oe = dat_low_q;
  assign cmd_ready  = (state_q == TX_IDLE);
  assign busy       = (state_q != TX_IDLE);

  // R3
  inhibit_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ps2_clk_oe) |-> !ps2_dat_oe);

  // R4
  clk_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ps2_clk_oe) |-> ps2_dat_oe);

  // R10
  lines_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!ps2_clk_oe && !ps2_dat_oe));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  ack_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_ok) |-> (done && !err));

endmodule

// File: tb/ps2_host_tx_tb_top.sv
module ps2_host_tx_tb_top;

  localparam int INH  = 20;
  localparam int TO   = 300;
  localparam int HALF = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_data = 8'h00;
  logic       cmd_ready, ps2_clk_oe, ps2_dat_oe, busy, done, ack_ok, err;
  logic       dev_clk_low = 1'b0;
  logic       dev_dat_low = 1'b0;

  wire ps2_clk_line = !(ps2_clk_oe || dev_clk_low);
  wire ps2_dat_line = !(ps2_dat_oe || dev_dat_low);

  int vec = 0;
  int bad = 0;
  bit finished = 1'b0;
  int dev_mode = 0;   // 0 normal, 1 no acknowledge, 2 silent, 3 stops after four pulses

  logic [7:0] byte_q[$];
  bit         outc_q[$];   // 1: acknowledge expected

  always #4 clk = ~clk;

  ps2_host_tx #(.DATA_W(8), .SYNC_STAGES(2), .INHIBIT_CYC(INH), .TIMEOUT_CYC(TO)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .ps2_clk_i(ps2_clk_line), .ps2_dat_i(ps2_dat_line),
    .ps2_clk_oe(ps2_clk_oe), .ps2_dat_oe(ps2_dat_oe), .busy(busy), .done(done),
    .ack_ok(ack_ok), .err(err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    end
  endtask

  // device model: clocks the frame once it sees the request
  task automatic run_device();
    logic [10:0] bits;
    logic [7:0]  exp;
    int          npulse;
    bits    = '0;
    bits[0] = ps2_dat_line;
    chk(bits[0] == 1'b0, "R4 start bit", bits[0], 0);
    if (dev_mode == 2) begin
      while (busy) @(negedge clk);
      return;
    end
    npulse = (dev_mode == 3) ? 4 : 10;
    repeat (HALF) @(negedge clk);
    for (int k = 1; k <= npulse; k++) begin
      dev_clk_low = 1'b1;
      repeat (HALF) @(negedge clk);
      dev_clk_low = 1'b0;
      bits[k] = ps2_dat_line;
      repeat (HALF) @(negedge clk);
    end
    if (dev_mode == 3) begin
      while (busy) @(negedge clk);
      return;
    end
    if (dev_mode == 0) dev_dat_low = 1'b1;
    repeat (2) @(negedge clk);
    dev_clk_low = 1'b1;
    repeat (HALF) @(negedge clk);
    dev_clk_low = 1'b0;
    repeat (HALF) @(negedge clk);
    dev_dat_low = 1'b0;
    if (byte_q.size() == 0) begin
      chk(1'b0, "R2 unexpected frame", bits[8:1], 0);
    end else begin
      exp = byte_q.pop_front();
      chk(bits[8:1] == exp, "R5 data LSB first", bits[8:1], exp);
      chk(bits[9] == ~(^exp), "R6 odd parity", bits[9], ~(^exp));
      chk(bits[10] == 1'b1, "R7 stop bit", bits[10], 1);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && busy && !ps2_clk_oe && ps2_clk_line && !ps2_dat_line) run_device();
    end
  end

  // monitor: compares each completion against the expected outcome
  initial begin
    bit exp_ack;
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        if (outc_q.size() == 0) begin
          chk(1'b0, "R2 unexpected completion", 1, 0);
        end else begin
          exp_ack = outc_q.pop_front();
          if (exp_ack) chk(ack_ok && !err, "R8 acknowledge", {ack_ok, err}, 2'b10);
          else         chk(err && !ack_ok, "R9_R10 error flag", {ack_ok, err}, 2'b01);
        end
        chk(!ps2_clk_oe && !ps2_dat_oe, "R10 lines released", {ps2_clk_oe, ps2_dat_oe}, 0);
        @(negedge clk);
        chk(!done, "R11 done width", done, 0);
      end
    end
  end

  task automatic send(input logic [7:0] b, input bit exp_ack, input bit push_byte,
                      output int xfer_cyc);
    int n;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R2 ready when idle", cmd_ready, 1);
    outc_q.push_back(exp_ack);
    if (push_byte) byte_q.push_back(b);
    cmd_valid = 1'b1;
    cmd_data  = b;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy && !cmd_ready, "R2 busy after accept", {busy, cmd_ready}, 2'b10);
    chk(!ack_ok && !err, "R11 flags cleared", {ack_ok, err}, 0);
    n = 0;
    while (ps2_clk_oe && !ps2_dat_oe && n < INH + 10) begin
      n++;
      @(negedge clk);
    end
    chk(n == INH, "R3 inhibit length", n, INH);
    chk(ps2_clk_oe && ps2_dat_oe, "R4 request overlap", {ps2_clk_oe, ps2_dat_oe}, 2'b11);
    @(negedge clk);
    chk(!ps2_clk_oe && ps2_dat_oe, "R4 clock released", {ps2_clk_oe, ps2_dat_oe}, 2'b01);
    xfer_cyc = 0;
    while (busy) begin
      xfer_cyc++;
      @(negedge clk);
    end
    repeat (5) @(negedge clk);
    chk(ack_ok == exp_ack && err == !exp_ack, "R11 flags held", {ack_ok, err},
        {exp_ack, !exp_ack});
    repeat (3 * HALF) @(negedge clk);
  endtask

  initial begin
    int  cyc;
    bit  ready_seen;
    bit  busy_seen;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready && !busy && !done && !ps2_clk_oe && !ps2_dat_oe, "R1 reset state",
        {cmd_ready, busy, done, ps2_clk_oe, ps2_dat_oe}, 5'b10000);

    dev_mode = 0;
    send(8'h00, 1'b1, 1'b1, cyc);
    send(8'hFF, 1'b1, 1'b1, cyc);
    send(8'hA5, 1'b1, 1'b1, cyc);
    send(8'h01, 1'b1, 1'b1, cyc);
    send(8'h80, 1'b1, 1'b1, cyc);
    send(8'hF4, 1'b1, 1'b1, cyc);

    // R2: a byte offered mid-transfer must wait and never start a frame
    ready_seen = 1'b0;
    fork
      send(8'h6B, 1'b1, 1'b1, cyc);
      begin
        repeat (INH + 40) @(negedge clk);
        cmd_valid = 1'b1;
        cmd_data  = 8'h3C;
        repeat (30) begin
          @(negedge clk);
          if (cmd_ready) ready_seen = 1'b1;
        end
        cmd_valid = 1'b0;
      end
    join
    chk(!ready_seen, "R2 ready low while busy", ready_seen, 0);
    busy_seen = 1'b0;
    repeat (60) begin
      @(negedge clk);
      if (busy) busy_seen = 1'b1;
    end
    chk(!busy_seen && byte_q.size() == 0, "R2 offered byte ignored", busy_seen, 0);

    dev_mode = 1;
    send(8'hF3, 1'b0, 1'b1, cyc);

    dev_mode = 2;
    send(8'h55, 1'b0, 1'b0, cyc);
    chk(cyc == TO, "R10 timeout after request", cyc, TO);

    dev_mode = 3;
    send(8'h81, 1'b0, 1'b0, cyc);

    dev_mode = 0;
    send(8'hE7, 1'b1, 1'b1, cyc);

    chk(outc_q.size() == 0, "R8 all outcomes seen", outc_q.size(), 0);
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog R1 run did not end actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
    end
  end

endmodule